// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave Controller

This block is the slave side of a serial memory reached over a four-wire SPI link. A register array on chip plays the part of the nonvolatile cells. The host selects the block by pulling chip select low. It then shifts in an 8-bit command, most significant bit first, followed where needed by a 16-bit address and data bytes. Both SPI mode 0 and mode 3 are accepted: SI is taken on rising SCK edges and SO moves on falling SCK edges.

CS, SCK and SI are oversampled by the system clock through two-flop synchronizers, so SCK is treated as data and never used as a clock. The host can read the status byte, write the protection and enable bits, stream reads across the whole array, and fill a 64-byte page buffer that is committed after CS rises. Each commit holds the block busy for a programmed number of system clocks, which stands in for the self-timed cell programming. A separate guard decides whether the target page sits inside the block-protected region.

Top module: `spi_nvm_slave`

## Requirements
- R1: A command byte is valid only when its upper four bits are 0000. Bit 3 is ignored. Bits 2..0 select the command: 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array.
- R2: In both SPI mode 0 and mode 3, each byte is shifted most significant bit first. SI is captured on rising SCK edges, and SO changes only after falling SCK edges.
- R3: A byte with bits 2..0 equal to 000 or 111, or with any of bits 7..4 set, is invalid. After an invalid byte, so_oe stays low and nothing takes effect until CS falls again.
- R4: An array read takes a 16-bit address, of which only the low ADDR_W bits are used. Bytes then stream out from consecutive addresses, and the address wraps from the top of the array to 0.
- R5: During an array write, only the low 6 address bits advance after each byte, so data stays inside one 64-byte page. A later byte overwrites an earlier byte that landed on the same index.
- R6: Programming starts only when CS rises after at least one whole data byte, with no partial byte pending, and with the write-enable latch set. Otherwise the write is dropped.
- R7: The status read returns bit7=protect-enable, bits 6..4=0, bits 3..2=block-protect level, bit1=write-enable latch and bit0=0 when idle. While programming is in progress it returns 0xFF.
- R8: After reset the write-enable latch is clear and the status byte reads 0x00. The latch clears when a programming cycle completes.
- R9: While programming is in progress, every command except the status read is ignored.
- R10: The block-protect level guards part of the array. Level 01 covers addresses whose top two bits are 11, level 10 covers addresses whose top bit is 1, and level 11 covers the whole array. A write to a page inside the guarded region is dropped and starts no cycle.
- R11: A status write with the latch set stores bit 7 and bits 3..2 of its data byte when the programming cycle ends.
- R12: A programming cycle keeps the block busy for exactly PROG_CYCLES system clocks.
- R13: so_oe is low whenever the block is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
Directed sequences first walk through the command set, invalid bytes, a 66-byte write that wraps inside its page, a read that crosses the top address using an address with junk upper bits, and a write cut off in the middle of a byte. Each of these is checked against a byte model of the array and status register kept in the bench. Commands are issued while a cycle is running to show that only the status read still answers. Random page writes and reads then alternate between mode 0 and mode 3, with varying protection levels and with the latch randomly set or clear. This separates dropped writes, protected pages and in-page wrap from plain storage.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;

    localparam int PAGE_W = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_RDAT, ST_WDAT, ST_SRRD, ST_SRWR, ST_DEAD
    } nvm_state_e;

    typedef enum logic [2:0] {
        OP_WRSR  = 3'b001,
        OP_WRITE = 3'b010,
        OP_READ  = 3'b011,
        OP_WRDI  = 3'b100,
        OP_RDSR  = 3'b101,
        OP_WREN  = 3'b110
    } nvm_op_e;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
        logic       wel;
    } nvm_stat_t;

    function automatic logic op_valid(logic [7:0] b);
        return (b[7:4] == 4'b0000) && (b[2:0] != 3'b000) && (b[2:0] != 3'b111);
    endfunction

    function automatic logic [7:0] stat_byte(nvm_stat_t s, logic busy);
        return busy ? 8'hFF : {s.wpen, 3'b000, s.bp, s.wel, 1'b0};
    endfunction

endpackage

// File: rtl/nvm_in_sync.sv
module nvm_in_sync (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic sel,
    output logic sel_fall,
    output logic sel_rise,
    output logic sck_rise,
    output logic sck_fall,
    output logic si_s
);
    logic [2:0] cs_sh, sck_sh;
    logic [1:0] si_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sh  <= 3'b111;
            sck_sh <= 3'b000;
            si_sh  <= 2'b00;
        end else begin
            cs_sh  <= {cs_sh[1:0], cs_n};
            sck_sh <= {sck_sh[1:0], sck};
            si_sh  <= {si_sh[0], si};
        end
    end

    assign sel      = !cs_sh[1];
    assign sel_fall = !cs_sh[1] && cs_sh[2];
    assign sel_rise = cs_sh[1] && !cs_sh[2];
    assign sck_rise = sck_sh[1] && !sck_sh[2];
    assign sck_fall = !sck_sh[1] && sck_sh[2];
    assign si_s     = si_sh[1];
endmodule

// File: rtl/nvm_guard.sv
module nvm_guard #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        bp,
    output logic              locked
);
    always_comb begin
        unique case (bp)
            2'b01:   locked = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10:   locked = addr[ADDR_W-1];
            2'b11:   locked = 1'b1;
            default: locked = 1'b0;
        endcase
    end
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer #(
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PROG_CYCLES + 1);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= CW'(PROG_CYCLES - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
    import spi_nvm_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PROG_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic so_oe
);
    localparam int PW    = PAGE_W;
    localparam int PAGE  = 1 << PW;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HW    = ADDR_W - PW;

    logic sel, sel_fall, sel_rise, sck_rise, sck_fall, si_s;
    logic busy, done, start, start_w, start_s, page_locked;

    nvm_state_e        state_q;
    logic [2:0]        bitcnt_q;
    logic [6:0]        rx_q;
    logic [7:0]        ahi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              is_wr_q;
    logic [7:0]        tx_q;
    logic              so_q, oe_q;
    nvm_stat_t         stat_q;
    logic [7:0]        sr_pend_q;
    logic              sr_have_q;
    logic [PAGE-1:0]   pvalid_q;
    logic              prog_wr_q;
    logic [HW-1:0]     wpage_q;
    logic [7:0]        pbuf [PAGE];
    logic [7:0]        mem  [DEPTH];

    logic [7:0]        byte_in;
    logic [ADDR_W-1:0] full_addr;
    logic              byte_done;

    nvm_in_sync u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .sel(sel), .sel_fall(sel_fall), .sel_rise(sel_rise),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
    );

    nvm_guard #(.ADDR_W(ADDR_W)) u_guard (
        .addr({addr_q[ADDR_W-1:PW], {PW{1'b0}}}),
        .bp(stat_q.bp),
        .locked(page_locked)
    );

    nvm_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done)
    );

    assign byte_in   = {rx_q, si_s};
    assign full_addr = ADDR_W'({ahi_q, byte_in});
    assign byte_done = sel && sck_rise && (bitcnt_q == 3'd7);

    assign start_w = (state_q == ST_WDAT) && (bitcnt_q == 3'd0) && (|pvalid_q)
                     && stat_q.wel && !busy && !page_locked;
    assign start_s = (state_q == ST_SRWR) && (bitcnt_q == 3'd0) && sr_have_q
                     && stat_q.wel && !busy;
    assign start   = sel_rise && (start_w || start_s);

    assign so    = so_q;
    assign so_oe = oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bitcnt_q  <= '0;
            rx_q      <= '0;
            ahi_q     <= '0;
            addr_q    <= '0;
            is_wr_q   <= 1'b0;
            tx_q      <= '0;
            so_q      <= 1'b0;
            oe_q      <= 1'b0;
            stat_q    <= '0;
            sr_pend_q <= '0;
            sr_have_q <= 1'b0;
            pvalid_q  <= '0;
            prog_wr_q <= 1'b0;
            wpage_q   <= '0;
        end else begin
            if (done) begin
                stat_q.wel <= 1'b0;
                if (!prog_wr_q) begin
                    stat_q.wpen <= sr_pend_q[7];
                    stat_q.bp   <= sr_pend_q[3:2];
                end
            end
            if (sel_fall) begin
                state_q  <= ST_OPC;
                bitcnt_q <= '0;
                oe_q     <= 1'b0;
            end else if (sel_rise) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
                if (start_w) begin
                    prog_wr_q <= 1'b1;
                    wpage_q   <= addr_q[ADDR_W-1:PW];
                end else if (start_s) begin
                    prog_wr_q <= 1'b0;
                end
            end else if (sel && sck_rise) begin
                rx_q     <= byte_in[6:0];
                bitcnt_q <= bitcnt_q + 3'd1;
                if (bitcnt_q == 3'd7) begin
                    unique case (state_q)
                        ST_OPC: begin
                            if (!op_valid(byte_in)) begin
                                state_q <= ST_DEAD;
                            end else if (busy) begin
                                if (byte_in[2:0] == OP_RDSR) begin
                                    state_q <= ST_SRRD;
                                    tx_q    <= stat_byte(stat_q, busy);
                                    oe_q    <= 1'b1;
                                end else begin
                                    state_q <= ST_DEAD;
                                end
                            end else begin
                                case (byte_in[2:0])
                                    OP_WREN: begin
                                        stat_q.wel <= 1'b1;
                                        state_q    <= ST_DEAD;
                                    end
                                    OP_WRDI: begin
                                        stat_q.wel <= 1'b0;
                                        state_q    <= ST_DEAD;
                                    end
                                    OP_RDSR: begin
                                        state_q <= ST_SRRD;
                                        tx_q    <= stat_byte(stat_q, busy);
                                        oe_q    <= 1'b1;
                                    end
                                    OP_WRSR: begin
                                        state_q   <= ST_SRWR;
                                        sr_have_q <= 1'b0;
                                    end
                                    OP_READ: begin
                                        state_q <= ST_AHI;
                                        is_wr_q <= 1'b0;
                                    end
                                    default: begin
                                        state_q <= ST_AHI;
                                        is_wr_q <= 1'b1;
                                    end
                                endcase
                            end
                        end
                        ST_AHI: begin
                            ahi_q   <= byte_in;
                            state_q <= ST_ALO;
                        end
                        ST_ALO: begin
                            if (is_wr_q) begin
                                state_q  <= ST_WDAT;
                                addr_q   <= full_addr;
                                pvalid_q <= '0;
                            end else begin
                                state_q <= ST_RDAT;
                                tx_q    <= mem[full_addr];
                                addr_q  <= full_addr + 1'b1;
                                oe_q    <= 1'b1;
                            end
                        end
                        ST_RDAT: begin
                            tx_q   <= mem[addr_q];
                            addr_q <= addr_q + 1'b1;
                        end
                        ST_SRRD: tx_q <= stat_byte(stat_q, busy);
                        ST_SRWR: begin
                            sr_pend_q <= byte_in;
                            sr_have_q <= 1'b1;
                        end
                        ST_WDAT: begin
                            pvalid_q[addr_q[PW-1:0]] <= 1'b1;
                            addr_q[PW-1:0]           <= addr_q[PW-1:0] + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end else if (sel && sck_fall) begin
                so_q <= tx_q[7];
                tx_q <= {tx_q[6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (byte_done && state_q == ST_WDAT) begin
            pbuf[addr_q[PW-1:0]] <= byte_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (done && prog_wr_q) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (pvalid_q[PW'(i)] && (HW'(i >> PW) == wpage_q)) begin
                    mem[i] <= pbuf[PW'(i)];
                end
            end
        end
    end
endmodule

// File: rtl/nvm_checker.sv
module nvm_checker #(
    parameter int PROG_CYCLES = 5000
) (
    input logic clk,
    input logic rst,
    input logic sel,
    input logic sck_fall,
    input logic so,
    input logic so_oe,
    input logic busy,
    input logic wel,
    input logic dead
);
    logic [31:0] busy_len;

    always_ff @(posedge clk) begin
        if (rst) busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1;
        else busy_len <= '0;
    end

    assert_so_edge_R2: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(so));

    assert_dead_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        dead |-> !so_oe);

    assert_wel_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || wel == $past(wel)));

    assert_prog_len_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_len == PROG_CYCLES));

    assert_oe_desel_R13: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !so_oe);
endmodule

bind spi_nvm_slave nvm_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sel(sel), .sck_fall(sck_fall), .so(so),
    .so_oe(so_oe), .busy(busy), .wel(stat_q.wel),
    .dead(state_q == spi_nvm_pkg::ST_DEAD)
);

// File: tb/sim_spi_nvm_slave.sv
module sim_spi_nvm_slave;
    localparam int AW = 8;
    localparam int PCYC = 800;
    localparam int H = 6;

    logic clk = 0, rst = 1, cs_n = 1, sck = 0, si = 0;
    logic so, so_oe;
    logic mode3 = 0, oe_seen = 0;
    int checks = 0, failures = 0;

    logic [7:0] mdl [256];
    logic       m_wel = 0, m_wpen = 0;
    logic [1:0] m_bp = 0;
    logic [7:0] wbuf [80];

    always #10 clk = ~clk;

    spi_nvm_slave #(.ADDR_W(AW), .PROG_CYCLES(PCYC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_stat();
        return {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    function automatic logic locked(logic [7:0] a, logic [1:0] bp);
        return (bp == 2'b11) || (bp == 2'b10 && a[7]) || (bp == 2'b01 && a[7:6] == 2'b11);
    endfunction

    task automatic start_tx();
        @(negedge clk);
        sck = mode3;
        repeat (2) @(negedge clk);
        cs_n = 0;
        oe_seen = 0;
        repeat (H) @(negedge clk);
    endtask

    task automatic end_tx();
        repeat (H) @(negedge clk);
        cs_n = 1;
        repeat (8) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] d, input int n, output logic [7:0] r);
        r = 0;
        for (int i = 7; i > 7 - n; i--) begin
            if (mode3) begin @(negedge clk); sck = 0; end
            @(negedge clk); si = d[i];
            repeat (H) @(negedge clk);
            r[i] = so;
            oe_seen = oe_seen | so_oe;
            sck = 1;
            repeat (H) @(negedge clk);
            oe_seen = oe_seen | so_oe;
            if (!mode3) sck = 0;
        end
    endtask

    task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
        xbits(d, 8, r);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        start_tx(); xbyte(op, r); end_tx();
    endtask

    task automatic rdsr(output logic [7:0] st);
        logic [7:0] r;
        start_tx(); xbyte(8'h05, r); xbyte(8'h00, st); end_tx();
    endtask

    task automatic wait_ready(input string tag);
        logic [7:0] st;
        int tries = 0;
        do begin rdsr(st); tries++; end while (st[0] && tries < 40);
        check(tag, {31'd0, st[0]}, 32'd0);
    endtask

    task automatic set_wel();
        cmd1(8'h06); m_wel = 1;
    endtask

    task automatic do_wrsr(input logic [7:0] v);
        logic [7:0] r;
        start_tx(); xbyte(8'h01, r); xbyte(v, r); end_tx();
        if (m_wel) begin
            m_wpen = v[7]; m_bp = v[3:2]; m_wel = 0;
            wait_ready("R12 status cycle ends");
        end
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input int partial, output logic began);
        logic [7:0] r;
        start_tx(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) xbyte(wbuf[k], r);
        if (partial > 0) xbits(8'hA5, partial, r);
        end_tx();
        began = m_wel && !locked(a[7:0], m_bp) && n > 0 && partial == 0;
        if (began) begin
            for (int k = 0; k < n; k++)
                mdl[{a[7:6], 6'(a[5:0] + 6'(k))}] = wbuf[k];
            m_wel = 0;
        end
    endtask

    task automatic do_read(input string tag, input logic [15:0] a, input int n);
        logic [7:0] r;
        start_tx(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, r);
            check(tag, {24'd0, r}, {24'd0, mdl[8'(a[7:0] + 8'(k))]});
        end
        end_tx();
    endtask

    initial begin
        logic [7:0] st;
        logic began;
        int unsigned seed;
        seed = $urandom(32'h5EED);
        for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (5) @(negedge clk);

        check("R8 so_oe after reset", {31'd0, so_oe}, 32'd0);
        rdsr(st); check("R8 status after reset", {24'd0, st}, 32'h00);

        cmd1(8'h0E); m_wel = 1;
        rdsr(st); check("R1 set latch with bit3 high", {24'd0, st}, 32'h02);
        cmd1(8'h04); m_wel = 0;
        rdsr(st); check("R1 clear latch", {24'd0, st}, 32'h00);

        start_tx(); xbyte(8'h07, st); xbyte(8'h00, st); xbyte(8'h00, st); end_tx();
        check("R3 no output after code 111", {31'd0, oe_seen}, 32'd0);
        start_tx(); xbyte(8'h16, st); xbyte(8'h00, st); end_tx();
        check("R3 no output with upper bits set", {31'd0, oe_seen}, 32'd0);
        rdsr(st); check("R3 invalid byte left status", {24'd0, st}, 32'h00);
        check("R13 so_oe low when deselected", {31'd0, so_oe}, 32'd0);

        set_wel();
        start_tx(); xbyte(8'h01, st); xbyte(8'h8C, st); end_tx();
        rdsr(st); check("R7 status reads FF while busy", {24'd0, st}, 32'hFF);
        m_wpen = 1; m_bp = 2'b11; m_wel = 0;
        wait_ready("R12 status write finishes");
        rdsr(st); check("R11 status bits stored", {24'd0, st}, 32'h8C);
        set_wel(); do_wrsr(8'h04);
        rdsr(st); check("R11 level 01 stored", {24'd0, st}, 32'h04);

        set_wel();
        wbuf[0] = 8'h3C;
        do_write(16'h00C5, 1, 0, began);
        rdsr(st); check("R10 guarded write starts no cycle", {24'd0, st}, {24'd0, exp_stat()});
        do_read("R10 guarded byte unchanged", 16'h00C5, 1);
        wbuf[0] = 8'h5A;
        do_write(16'h0085, 1, 0, began);
        wait_ready("R12 page write finishes");
        do_read("R10 open page written", 16'h0085, 1);

        cmd1(8'h04); m_wel = 0;
        wbuf[0] = 8'h11;
        do_write(16'h0010, 1, 0, began);
        rdsr(st); check("R6 no latch no cycle", {24'd0, st}, 32'h04);
        do_read("R6 no latch byte unchanged", 16'h0010, 1);

        set_wel();
        wbuf[0] = 8'h22;
        do_write(16'h0011, 1, 3, began);
        rdsr(st); check("R6 partial byte no cycle", {24'd0, st}, 32'h06);
        do_read("R6 partial byte unchanged", 16'h0011, 1);

        do_wrsr(8'h00);
        set_wel();
        for (int k = 0; k < 66; k++) wbuf[k] = 8'(k * 7 + 3);
        do_write(16'h003E, 66, 0, began);
        rdsr(st); check("R7 busy after page write", {24'd0, st}, 32'hFF);
        cmd1(8'h06);
        start_tx(); xbyte(8'h03, st); xbyte(8'h00, st); xbyte(8'h00, st); xbyte(8'h00, st); end_tx();
        check("R9 read ignored while busy", {31'd0, oe_seen}, 32'd0);
        wait_ready("R12 wrapped write finishes");
        rdsr(st); check("R9 latch request ignored while busy", {24'd0, st}, 32'h00);
        do_read("R5 in-page wrap", 16'h0000, 64);

        do_read("R4 wrap over top with junk upper bits", 16'hA5FE, 4);

        for (int it = 0; it < 16; it++) begin
            logic [15:0] a;
            int n;
            mode3 = it[0];
            if (it % 4 == 0) begin set_wel(); do_wrsr({6'd0, 2'($urandom_range(0, 2)), 2'b00} << 0); end
            a = 16'($urandom);
            n = $urandom_range(1, 8);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            if ($urandom_range(0, 3) != 0) set_wel();
            do_write(a, n, 0, began);
            if (began) wait_ready("R12 random write finishes");
            do_read(mode3 ? "R2 mode 3 readback" : "R2 mode 0 readback", a, n + 2);
            rdsr(st); check("R7 status after random op", {24'd0, st}, {24'd0, exp_stat()});
        end

        summary();
        $finish;
    end
endmodule